// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block keeps a small table with one slot per SDRAM bank number. Each slot holds an open flag, the chip select that opened it and the row that was activated. A memory controller presents each incoming read or write (chip select, bank, row and an auto-precharge flag). One clock later the block answers with one of three outcomes:

- **hit**: the row is already open, so the column command can go out at once.
- **conflict**: a different row, or the same row on another chip select, is open. The bank must be precharged on the chip select that is reported, then activated.
- **closed**: only an activate is needed.

The controller reports every activate, precharge, access with auto-precharge and precharge-all that it issues. The table follows those reports. The refresh logic reads the any-open output to decide whether a precharge-all has to come before an auto-refresh.

Top module: `bank_row_tracker`

## Requirements
- R1: While reset is held, and until the first activate report after it, every slot is closed. `any_open` is 0. `rsp_valid`, `rsp_hit`, `rsp_conflict`, `rsp_closed`, `rsp_ap` and `rsp_pre_cs` are all 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. In that cycle exactly one of `rsp_hit`, `rsp_conflict` and `rsp_closed` is 1. In any other cycle all four are 0.
- R3: A request whose bank slot is open with the same chip select and the same row gives `rsp_hit`.
- R4: A request whose bank slot is open with the same chip select but a different row gives `rsp_conflict`. `rsp_pre_cs` then carries the chip select stored in the slot.
- R5: A request whose bank slot is open under a different chip select gives `rsp_conflict`, whatever the row. `rsp_pre_cs` carries the stored chip select. Outside a conflict, `rsp_pre_cs` is 0.
- R6: A request whose bank slot is closed gives `rsp_closed`.
- R7: A report with `cmd_kind` = 2'b00 (activate) opens slot `cmd_bank` and stores `cmd_cs` and `cmd_row`, replacing any earlier contents.
- R8: A report with `cmd_kind` = 2'b01 (precharge) closes slot `cmd_bank` only when its stored chip select equals `cmd_cs`. With a different chip select the slot is left as it was.
- R9: A report with `cmd_kind` = 2'b10 (read or write issued with auto-precharge) closes slot `cmd_bank` under the same chip-select rule as R8.
- R10: A report with `cmd_kind` = 2'b11 (precharge-all) closes every slot, whatever `cmd_cs` and `cmd_bank` hold.
- R11: `any_open` is 1 exactly when at least one slot is open. The change from a report shows in the cycle after that report.
- R12: When a request and a report arrive in the same cycle, the outcome is decided on the table as it stood before that report.
- R13: `rsp_ap` equals the `req_ap` of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cs | input | CS_W (3) | Encoded chip select of the request |
| req_bank | input | BANK_W (2) | Bank of the request |
| req_row | input | ROW_W (14) | Row of the request |
| req_ap | input | 1 | Request asks for auto-precharge |
| cmd_valid | input | 1 | Issued-command report strobe |
| cmd_kind | input | 2 | 00 activate, 01 precharge, 10 access with auto-precharge, 11 precharge-all |
| cmd_cs | input | CS_W (3) | Chip select of the reported command |
| cmd_bank | input | BANK_W (2) | Bank of the reported command |
| cmd_row | input | ROW_W (14) | Row of a reported activate |
| rsp_valid | output | 1 | Outcome valid |
| rsp_hit | output | 1 | Row already open |
| rsp_conflict | output | 1 | Precharge, then activate |
| rsp_closed | output | 1 | Activate only |
| rsp_ap | output | 1 | Auto-precharge flag of the answered request |
| rsp_pre_cs | output | CS_W (3) | Chip select to precharge on a conflict |
| any_open | output | 1 | At least one slot open |

## Verification
The outcome of a request sampled at clock edge k is due in the cycle after edge k. A table change made by a report at edge k is seen by requests sampled at edge k+1 onward, and by `any_open` right after edge k. The bench drives inputs on the falling edge and compares outputs on the next falling edge. Its reference model computes each expected outcome from the model state before applying that cycle's report, which also covers R12. Random traffic is kept to a few rows and chip selects so that hits, row conflicts and chip-select conflicts all occur often.

// File: rtl/brt_pkg.sv
package brt_pkg;
   typedef enum logic [1:0] {
      CMD_ACT     = 2'b00,
      CMD_PRE     = 2'b01,
      CMD_ACC_AP  = 2'b10,
      CMD_PRE_ALL = 2'b11
   } cmd_kind_e;
endpackage

// File: rtl/brt_slot.sv
module brt_slot
   import brt_pkg::*;
#(
   parameter int CS_W   = 3,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 14,
   parameter int IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   input  logic [CS_W-1:0]   cmd_cs,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_W-1:0]  cmd_row,
   output logic              open_o,
   output logic [CS_W-1:0]   cs_o,
   output logic [ROW_W-1:0]  row_o
);
   localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(IDX);

   logic sel;
   logic owner;

   assign sel   = (cmd_bank == MY_BANK);
   assign owner = sel && (cmd_cs == cs_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         cs_o   <= '0;
         row_o  <= '0;
      end else if (cmd_valid) begin
         unique case (cmd_kind_e'(cmd_kind))
            CMD_ACT: begin
               if (sel) begin
                  open_o <= 1'b1;
                  cs_o   <= cmd_cs;
                  row_o  <= cmd_row;
               end
            end
            CMD_PRE, CMD_ACC_AP: begin
               if (owner) open_o <= 1'b0;
            end
            CMD_PRE_ALL: open_o <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/brt_decide.sv
module brt_decide #(
   parameter int CS_W    = 3,
   parameter int BANK_W  = 2,
   parameter int ROW_W   = 14,
   parameter int ENTRIES = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [CS_W-1:0]                req_cs,
   input  logic [BANK_W-1:0]              req_bank,
   input  logic [ROW_W-1:0]               req_row,
   input  logic                           req_ap,
   input  logic [ENTRIES-1:0]             open_vec,
   input  logic [ENTRIES-1:0][CS_W-1:0]   cs_vec,
   input  logic [ENTRIES-1:0][ROW_W-1:0]  row_vec,
   output logic                           rsp_valid,
   output logic                           rsp_hit,
   output logic                           rsp_conflict,
   output logic                           rsp_closed,
   output logic                           rsp_ap,
   output logic [CS_W-1:0]                rsp_pre_cs
);
   logic            slot_open;
   logic            tag_same;
   logic [CS_W-1:0] slot_cs;

   always_comb begin
      slot_open = open_vec[req_bank];
      slot_cs   = cs_vec[req_bank];
      tag_same  = (slot_cs == req_cs) && (row_vec[req_bank] == req_row);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_conflict <= 1'b0;
         rsp_closed   <= 1'b0;
         rsp_ap       <= 1'b0;
         rsp_pre_cs   <= '0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_hit      <= req_valid && slot_open && tag_same;
         rsp_conflict <= req_valid && slot_open && !tag_same;
         rsp_closed   <= req_valid && !slot_open;
         rsp_ap       <= req_valid && req_ap;
         rsp_pre_cs   <= (req_valid && slot_open && !tag_same) ? slot_cs : '0;
      end
   end
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
   parameter int CS_W   = 3,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic              req_ap,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   input  logic [CS_W-1:0]   cmd_cs,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_W-1:0]  cmd_row,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_conflict,
   output logic              rsp_closed,
   output logic              rsp_ap,
   output logic [CS_W-1:0]   rsp_pre_cs,
   output logic              any_open
);
   localparam int ENTRIES = 1 << BANK_W;

   if (ROW_W < 1 || ROW_W > 14) begin : g_bad_row
      $error("bank_row_tracker: ROW_W must be 1..14");
   end
   if (BANK_W < 1 || BANK_W > 3) begin : g_bad_bank
      $error("bank_row_tracker: BANK_W must be 1..3");
   end
   if (CS_W < 1 || CS_W > 3) begin : g_bad_cs
      $error("bank_row_tracker: CS_W must be 1..3");
   end

   logic [ENTRIES-1:0]            open_vec;
   logic [ENTRIES-1:0][CS_W-1:0]  cs_vec;
   logic [ENTRIES-1:0][ROW_W-1:0] row_vec;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      brt_slot #(
         .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .IDX(i)
      ) i_slot (
         .clk(clk), .rst_n(rst_n),
         .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_cs(cmd_cs),
         .cmd_bank(cmd_bank), .cmd_row(cmd_row),
         .open_o(open_vec[i]), .cs_o(cs_vec[i]), .row_o(row_vec[i])
      );
   end

   brt_decide #(
      .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .ENTRIES(ENTRIES)
   ) i_decide (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cs(req_cs), .req_bank(req_bank),
      .req_row(req_row), .req_ap(req_ap),
      .open_vec(open_vec), .cs_vec(cs_vec), .row_vec(row_vec),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_conflict(rsp_conflict),
      .rsp_closed(rsp_closed), .rsp_ap(rsp_ap), .rsp_pre_cs(rsp_pre_cs)
   );

   assign any_open = |open_vec;
endmodule

// File: rtl/brt_chk.sv
module brt_chk #(
   parameter int CS_W   = 3,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [CS_W-1:0]   req_cs,
   input logic [BANK_W-1:0] req_bank,
   input logic [ROW_W-1:0]  req_row,
   input logic              req_ap,
   input logic              cmd_valid,
   input logic [1:0]        cmd_kind,
   input logic [CS_W-1:0]   cmd_cs,
   input logic [BANK_W-1:0] cmd_bank,
   input logic [ROW_W-1:0]  cmd_row,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_conflict,
   input logic              rsp_closed,
   input logic              rsp_ap,
   input logic [CS_W-1:0]   rsp_pre_cs,
   input logic              any_open
);
   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_conflict, rsp_closed}) == 1);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_conflict || rsp_closed || rsp_ap));

   // R5
   pre_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_conflict |-> rsp_pre_cs == '0);

   // R7
   act_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(cmd_valid) && $past(cmd_kind) == 2'b00 &&
       req_cs == $past(cmd_cs) && req_bank == $past(cmd_bank) &&
       req_row == $past(cmd_row)) |=> rsp_hit);

   // R10
   pre_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'b11) |=> !any_open);

   // R11
   act_sets_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'b00) |=> any_open);

   // R13
   ap_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_ap == $past(req_ap));
endmodule

bind bank_row_tracker brt_chk #(
   .CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
) i_brt_chk (.*);

// File: tb/test_bank_row_tracker.sv
module test_bank_row_tracker;
   localparam int CS_W = 3, BANK_W = 2, ROW_W = 14, NB = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_ap = 1'b0;
   logic [CS_W-1:0]   req_cs = '0;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_kind = '0;
   logic [CS_W-1:0]   cmd_cs = '0;
   logic [BANK_W-1:0] cmd_bank = '0;
   logic [ROW_W-1:0]  cmd_row = '0;
   logic              rsp_valid, rsp_hit, rsp_conflict, rsp_closed, rsp_ap, any_open;
   logic [CS_W-1:0]   rsp_pre_cs;

   int checks = 0;
   int failures = 0;

   bit              m_open [NB];
   logic [CS_W-1:0] m_cs   [NB];
   logic [ROW_W-1:0] m_row [NB];

   always #5 clk = ~clk;

   bank_row_tracker i_bank_row_tracker (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected outcome: 0 hit, 1 conflict, 2 closed
   function automatic int exp_outcome(logic [CS_W-1:0] c, logic [BANK_W-1:0] b,
                                      logic [ROW_W-1:0] r);
      if (!m_open[b]) return 2;
      if (m_cs[b] == c && m_row[b] == r) return 0;
      return 1;
   endfunction

   function automatic bit model_any();
      bit a = 1'b0;
      for (int i = 0; i < NB; i++) a |= m_open[i];
      return a;
   endfunction

   task automatic model_update(bit v, logic [1:0] k, logic [CS_W-1:0] c,
                               logic [BANK_W-1:0] b, logic [ROW_W-1:0] r);
      if (!v) return;
      case (k)
         2'b00: begin m_open[b] = 1'b1; m_cs[b] = c; m_row[b] = r; end
         2'b01, 2'b10: if (m_cs[b] == c) m_open[b] = 1'b0;
         default: for (int i = 0; i < NB; i++) m_open[i] = 1'b0;
      endcase
   endtask

   // one cycle: drive at falling edge, compare at next falling edge
   task automatic step(string tag, bit rv, logic [CS_W-1:0] rc, logic [BANK_W-1:0] rb,
                       logic [ROW_W-1:0] rr, bit ra,
                       bit cv, logic [1:0] ck, logic [CS_W-1:0] cc,
                       logic [BANK_W-1:0] cb, logic [ROW_W-1:0] cr);
      int o;
      logic [CS_W-1:0] pcs;
      req_valid = rv; req_cs = rc; req_bank = rb; req_row = rr; req_ap = ra;
      cmd_valid = cv; cmd_kind = ck; cmd_cs = cc; cmd_bank = cb; cmd_row = cr;
      o = exp_outcome(rc, rb, rr);
      pcs = (rv && o == 1) ? m_cs[rb] : '0;
      model_update(cv, ck, cc, cb, cr);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R2 valid"}, 32'(rsp_valid), 32'(rv));
      chk({tag, " R3 hit"}, 32'(rsp_hit), 32'(rv && o == 0));
      chk({tag, " R4 conflict"}, 32'(rsp_conflict), 32'(rv && o == 1));
      chk({tag, " R6 closed"}, 32'(rsp_closed), 32'(rv && o == 2));
      chk({tag, " R5 pre_cs"}, 32'(rsp_pre_cs), 32'(pcs));
      chk({tag, " R13 ap"}, 32'(rsp_ap), 32'(rv && ra));
      chk({tag, " R11 any_open"}, 32'(any_open), 32'(model_any()));
   endtask

   task automatic req(string tag, logic [CS_W-1:0] c, logic [BANK_W-1:0] b,
                      logic [ROW_W-1:0] r, bit ap);
      step(tag, 1'b1, c, b, r, ap, 1'b0, 2'b00, '0, '0, '0);
   endtask

   task automatic cmd(string tag, logic [1:0] k, logic [CS_W-1:0] c,
                      logic [BANK_W-1:0] b, logic [ROW_W-1:0] r);
      step(tag, 1'b0, '0, '0, '0, 1'b0, 1'b1, k, c, b, r);
   endtask

   initial begin
      #(10 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < NB; i++) begin m_open[i] = 1'b0; m_cs[i] = '0; m_row[i] = '0; end
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 any_open", 32'(any_open), 0);
      chk("R1 rsp_valid", 32'(rsp_valid), 0);
      chk("R1 flags", 32'({rsp_hit, rsp_conflict, rsp_closed, rsp_ap, rsp_pre_cs}), 0);
      rst_n = 1'b1;
      req("R1 R6 closed after reset", 3'd1, 2'd2, 14'h123, 1'b0);
      // R7 activate then R3 hit
      cmd("R7 act", 2'b00, 3'd1, 2'd2, 14'h123);
      req("R3 hit", 3'd1, 2'd2, 14'h123, 1'b1);
      req("R4 row conflict", 3'd1, 2'd2, 14'h124, 1'b0);
      req("R5 cs conflict", 3'd3, 2'd2, 14'h123, 1'b0);
      req("R6 other bank closed", 3'd1, 2'd0, 14'h123, 1'b0);
      // R8 precharge from another chip select leaves the slot open
      cmd("R8 pre wrong cs", 2'b01, 3'd0, 2'd2, '0);
      req("R8 still hit", 3'd1, 2'd2, 14'h123, 1'b0);
      cmd("R8 pre", 2'b01, 3'd1, 2'd2, '0);
      req("R8 closed", 3'd1, 2'd2, 14'h123, 1'b0);
      // R9 access with auto-precharge
      cmd("R9 act", 2'b00, 3'd5, 2'd3, 14'h3fff);
      cmd("R9 acc_ap", 2'b10, 3'd5, 2'd3, '0);
      req("R9 closed", 3'd5, 2'd3, 14'h3fff, 1'b0);
      // R10 precharge-all
      cmd("R10 act0", 2'b00, 3'd0, 2'd0, 14'h1);
      cmd("R10 act1", 2'b00, 3'd7, 2'd1, 14'h2);
      cmd("R10 pre_all", 2'b11, 3'd4, 2'd2, '0);
      req("R10 closed0", 3'd0, 2'd0, 14'h1, 1'b0);
      // R12 same-cycle request and activate decide on the old table
      step("R12 same cycle", 1'b1, 3'd2, 2'd1, 14'h55, 1'b0, 1'b1, 2'b00, 3'd2, 2'd1, 14'h55);
      req("R12 then hit", 3'd2, 2'd1, 14'h55, 1'b0);
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         step("RND", 1'($urandom_range(0, 1)), 3'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), 14'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 2) == 0), 2'($urandom_range(0, 3)) & (($urandom_range(0, 5) == 0) ? 2'b11 : 2'b10) | 2'($urandom_range(0, 1)),
              3'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 14'($urandom_range(0, 2)));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule